// File: doc/BRIEF.md
# Per-Timeslot Channel Strobe Generator

This block tracks the position inside a 2.048 Mb/s serial frame of 32 timeslots with 8 bits each. Bits are carried least significant bit first within a timeslot. A single-cycle frame sync input realigns the count. One bit-clock cycle carries one bit of the frame. From that position the block drives two strobes for downstream serial logic. A channel clock marks the first bit of every timeslot. A channel block flag marks the bits of the timeslots that a downstream stage should treat specially, for example to skip or replace them.

The block flag has two sources. In mask mode, a 32-bit mask picks the timeslots: bit n of the mask selects timeslot n. In the fixed mode it uses the pattern for carrying a 1.544 Mb/s payload inside a 2.048 Mb/s frame. That pattern covers timeslots 1 through 15 and 17 through 25 in full, plus only the first bit of timeslot 26. The current timeslot and bit indices are also output, so that neighbouring logic can stay aligned.

Top module: `ts_strobe_gen`

## Requirements
- R1: While `rst_i` is high at a rising edge, the next outputs are `chan_clk_o` = 0, `chan_blk_o` = 0, `slot_idx_o` = 0 and `bit_idx_o` = 0.
- R2: With `rst_i` and `frame_sync_i` low at an edge, `bit_idx_o` advances by one. From 7 it wraps to 0, and `slot_idx_o` then advances by one. Slot 31 wraps to slot 0.
- R3: After any edge with `rst_i` low, `chan_clk_o` is 1 exactly when the new `bit_idx_o` is 0 (the first bit, the LSB, of a timeslot).
- R4: With `g802_mode_i` = 0, `chan_blk_o` equals bit `slot_idx_o` of the `mask_i` value sampled at the same edge, for all 8 bits of that timeslot.
- R5: With `g802_mode_i` = 1, `chan_blk_o` is 1 for every bit of timeslots 1–15 and 17–25, and 0 in timeslots 0, 16 and 27–31.
- R6: With `g802_mode_i` = 1, in timeslot 26 `chan_blk_o` is 1 only while `bit_idx_o` = 0 and is 0 for bit indices 1–7.
- R7: With `g802_mode_i` = 1, the value of `mask_i` has no effect on `chan_blk_o`.
- R8: A high `frame_sync_i` at any edge, including one in the middle of a frame, sets `slot_idx_o` and `bit_idx_o` to 0 after that edge, and `chan_clk_o` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one bit per rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| frame_sync_i | input | 1 | Frame start marker; the bit after it is timeslot 0, bit 0 |
| mask_i | input | 32 | Timeslot selection mask for mask mode |
| g802_mode_i | input | 1 | 1 selects the fixed 1.544-in-2.048 pattern |
| chan_clk_o | output | 1 | High on the first bit of each timeslot |
| chan_blk_o | output | 1 | High on bits of selected timeslots |
| slot_idx_o | output | 5 | Current timeslot, 0 to 31 |
| bit_idx_o | output | 3 | Current bit in the timeslot, 0 to 7 |

## Verification
Every output is a register loaded from the inputs seen at a single rising edge. Each result therefore belongs to exactly one edge, with no pipeline lag. The driver changes inputs on the falling edge and at the same time queues the expected values for the next rising edge. The monitor samples one nanosecond after that rising edge and compares the results against the oldest queued entry. This keeps each stimulus paired with the edge that consumes it, including reset cycles and mid-frame sync pulses.

// File: rtl/ts_strobe_pkg.sv
package ts_strobe_pkg;

    parameter int unsigned TS_SLOTS = 32;
    parameter int unsigned TS_BITS  = 8;

    localparam int unsigned SLOT_W = $clog2(TS_SLOTS);
    localparam int unsigned BIT_W  = $clog2(TS_BITS);

    // fixed 1.544-in-2.048 pattern boundaries
    parameter int unsigned G8_A_LO   = 1;
    parameter int unsigned G8_A_HI   = 15;
    parameter int unsigned G8_B_LO   = 17;
    parameter int unsigned G8_B_HI   = 25;
    parameter int unsigned G8_P_SLOT = 26;
    parameter int unsigned G8_P_BIT  = 0;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [BIT_W-1:0]  bidx_t;

    typedef struct packed {
        slot_t sidx;
        bidx_t bidx;
    } frame_pos_t;

    typedef enum logic {
        BLK_MASK = 1'b0,
        BLK_G802 = 1'b1
    } blk_mode_e;

    function automatic logic g802_full(input int unsigned s);
        return ((s >= G8_A_LO) && (s <= G8_A_HI)) ||
               ((s >= G8_B_LO) && (s <= G8_B_HI));
    endfunction

endpackage

// File: rtl/ts_pos_counter.sv
module ts_pos_counter
    import ts_strobe_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       sync_i,
    output frame_pos_t pos_q_o,
    output frame_pos_t pos_nxt_o
);

    localparam bidx_t BIT_LAST  = bidx_t'(TS_BITS - 1);
    localparam slot_t SLOT_LAST = slot_t'(TS_SLOTS - 1);

    frame_pos_t pos_q;
    frame_pos_t pos_nxt;

    always_comb begin
        pos_nxt = pos_q;
        if (rst_i || sync_i) begin
            pos_nxt = '0;
        end else if (pos_q.bidx == BIT_LAST) begin
            pos_nxt.bidx = '0;
            pos_nxt.sidx = (pos_q.sidx == SLOT_LAST) ? '0 : pos_q.sidx + 1'b1;
        end else begin
            pos_nxt.bidx = pos_q.bidx + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        pos_q <= pos_nxt;
    end

    assign pos_q_o   = pos_q;
    assign pos_nxt_o = pos_nxt;

    AST_BIT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sync_i && pos_q.bidx != BIT_LAST) |=> (pos_q.bidx == $past(pos_q.bidx) + 1'b1)); // R2

    AST_SLOT_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sync_i && pos_q.bidx == BIT_LAST && pos_q.sidx == SLOT_LAST) |=> (pos_q.sidx == '0)); // R2

    AST_SYNC_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_i |=> (pos_q == '0)); // R8

endmodule

// File: rtl/ts_strobe_decode.sv
module ts_strobe_decode
    import ts_strobe_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  frame_pos_t          pos_nxt_i,
    input  frame_pos_t          pos_cur_i,
    input  logic [TS_SLOTS-1:0] mask_i,
    input  blk_mode_e           mode_i,
    output logic                chan_clk_o,
    output logic                chan_blk_o
);

    localparam slot_t P_SLOT = slot_t'(G8_P_SLOT);
    localparam bidx_t P_BIT  = bidx_t'(G8_P_BIT);

    logic [TS_SLOTS-1:0] g8_full_vec;

    for (genvar s = 0; s < TS_SLOTS; s++) begin : g_slot_pat
        assign g8_full_vec[s] = g802_full(s);
    end

    logic blk_g8;
    logic blk_msk;
    logic blk_nxt;

    always_comb begin
        blk_g8  = g8_full_vec[pos_nxt_i.sidx] ||
                  ((pos_nxt_i.sidx == P_SLOT) && (pos_nxt_i.bidx == P_BIT));
        blk_msk = mask_i[pos_nxt_i.sidx];
        blk_nxt = (mode_i == BLK_G802) ? blk_g8 : blk_msk;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chan_clk_o <= 1'b0;
            chan_blk_o <= 1'b0;
        end else begin
            chan_clk_o <= (pos_nxt_i.bidx == '0);
            chan_blk_o <= blk_nxt;
        end
    end

    // sampled copies for the checks below
    logic [TS_SLOTS-1:0] mask_d;
    blk_mode_e           mode_d;
    always_ff @(posedge clk_i) begin
        mask_d <= mask_i;
        mode_d <= mode_i;
    end

    AST_CLK_ALIGN: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (chan_clk_o == (pos_cur_i.bidx == '0))); // R3

    AST_MASK_FOLLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == BLK_MASK) |=> (chan_blk_o == mask_d[pos_cur_i.sidx])); // R4

    AST_G802_PARTIAL: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == BLK_G802) |=>
            (!((pos_cur_i.sidx == P_SLOT) && (pos_cur_i.bidx != P_BIT)) || !chan_blk_o)); // R6

    AST_G802_EDGE_SLOTS: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == BLK_G802) |=>
            (!((pos_cur_i.sidx == '0) || (pos_cur_i.sidx == slot_t'(16))) || !chan_blk_o)); // R5

endmodule

// File: rtl/ts_strobe_gen.sv
module ts_strobe_gen
    import ts_strobe_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                frame_sync_i,
    input  logic [TS_SLOTS-1:0] mask_i,
    input  logic                g802_mode_i,
    output logic                chan_clk_o,
    output logic                chan_blk_o,
    output logic [SLOT_W-1:0]   slot_idx_o,
    output logic [BIT_W-1:0]    bit_idx_o
);

    frame_pos_t pos_q;
    frame_pos_t pos_nxt;
    blk_mode_e  mode;

    assign mode = g802_mode_i ? BLK_G802 : BLK_MASK;

    ts_pos_counter u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sync_i    (frame_sync_i),
        .pos_q_o   (pos_q),
        .pos_nxt_o (pos_nxt)
    );

    ts_strobe_decode u_dec (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .pos_nxt_i  (pos_nxt),
        .pos_cur_i  (pos_q),
        .mask_i     (mask_i),
        .mode_i     (mode),
        .chan_clk_o (chan_clk_o),
        .chan_blk_o (chan_blk_o)
    );

    assign slot_idx_o = pos_q.sidx;
    assign bit_idx_o  = pos_q.bidx;

endmodule

// File: tb/sim_ts_strobe_gen.sv
`timescale 1ns/1ps
module sim_ts_strobe_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        fsync;
    logic [31:0] mask;
    logic        g802;
    logic        chan_clk;
    logic        chan_blk;
    logic [4:0]  slot_idx;
    logic [2:0]  bit_idx;

    always #2 clk = ~clk;

    ts_strobe_gen u0 (
        .clk_i        (clk),
        .rst_i        (rst),
        .frame_sync_i (fsync),
        .mask_i       (mask),
        .g802_mode_i  (g802),
        .chan_clk_o   (chan_clk),
        .chan_blk_o   (chan_blk),
        .slot_idx_o   (slot_idx),
        .bit_idx_o    (bit_idx)
    );

    typedef struct {
        logic       clk_e;
        logic       blk_e;
        logic [4:0] slot_e;
        logic [2:0] bit_e;
        int         idx_tag;
        int         clk_tag;
        int         blk_tag;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    int   m_s    = 0;
    int   m_b    = 0;
    bit   drv_done = 0;

    function automatic string tag_s(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic g8_ref(input int s, input int b);
        if (s >= 1 && s <= 15) return 1'b1;
        if (s >= 17 && s <= 25) return 1'b1;
        if (s == 26 && b == 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic cyc(input logic r, input logic fs, input logic [31:0] m, input logic g);
        exp_t e;
        @(negedge clk);
        rst = r; fsync = fs; mask = m; g802 = g;
        if (r || fs) begin
            m_s = 0; m_b = 0;
        end else if (m_b == 7) begin
            m_b = 0; m_s = (m_s + 1) % 32;
        end else begin
            m_b = m_b + 1;
        end
        e.slot_e = 5'(m_s);
        e.bit_e  = 3'(m_b);
        if (r) begin
            e.clk_e = 1'b0; e.blk_e = 1'b0;
            e.idx_tag = 1; e.clk_tag = 1; e.blk_tag = 1;
        end else begin
            e.clk_e   = (m_b == 0);
            e.blk_e   = g ? g8_ref(m_s, m_b) : m[m_s];
            e.idx_tag = fs ? 8 : 2;
            e.clk_tag = 3;
            if (!g)            e.blk_tag = 4;
            else if (m_s == 26) e.blk_tag = 6;
            else if (m != 0)   e.blk_tag = 7;
            else               e.blk_tag = 5;
        end
        q.push_back(e);
    endtask

    task automatic run_n(input int n, input logic [31:0] m, input logic g);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, m, g);
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_run++;
                if (slot_idx !== e.slot_e || bit_idx !== e.bit_e) begin
                    n_fail++;
                    $display("FAIL %s index: got slot %0d bit %0d, expected slot %0d bit %0d",
                             tag_s(e.idx_tag), slot_idx, bit_idx, e.slot_e, e.bit_e);
                end
                n_run++;
                if (chan_clk !== e.clk_e) begin
                    n_fail++;
                    $display("FAIL %s chan_clk: got %b expected %b (slot %0d bit %0d)",
                             tag_s(e.clk_tag), chan_clk, e.clk_e, e.slot_e, e.bit_e);
                end
                n_run++;
                if (chan_blk !== e.blk_e) begin
                    n_fail++;
                    $display("FAIL %s chan_blk: got %b expected %b (slot %0d bit %0d)",
                             tag_s(e.blk_tag), chan_blk, e.blk_e, e.slot_e, e.bit_e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!drv_done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // driver
    initial begin
        rst = 1'b1; fsync = 1'b0; mask = '0; g802 = 1'b0;
        // R1 reset state
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 32'h0, 1'b0);
        // R8 align, then R2/R3/R4 with a single slot selected
        cyc(1'b0, 1'b1, 32'h0000_0004, 1'b0);
        run_n(300, 32'h0000_0004, 1'b0);
        // R4 first and last slot, across the 31->0 wrap
        cyc(1'b0, 1'b1, 32'h8000_0001, 1'b0);
        run_n(520, 32'h8000_0001, 1'b0);
        // R8 mid-frame sync
        run_n(37, 32'h00F0_0F00, 1'b0);
        cyc(1'b0, 1'b1, 32'h00F0_0F00, 1'b0);
        run_n(100, 32'h00F0_0F00, 1'b0);
        // R5/R6 fixed pattern, mask zero
        cyc(1'b0, 1'b1, 32'h0, 1'b1);
        run_n(270, 32'h0, 1'b1);
        // R7 fixed pattern with mask full and inverted pattern
        run_n(256, 32'hFFFF_FFFF, 1'b1);
        run_n(256, 32'hFC00_0000 | 32'h0001_0001, 1'b1);
        // R1 reset mid-run
        cyc(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1);
        cyc(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
        run_n(20, 32'hFFFF_FFFF, 1'b0);
        drv_done = 1;
        repeat (4) @(posedge clk);
        #2;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule